// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

This block is a synchronous static RAM with a processor-style burst port. The word is 18 bits wide: two 8-bit data bytes, each with its own parity bit. Address, write data, chip selects and write controls are all sampled on the rising clock. Output drive is gated asynchronously by an output-enable pin. A burst is opened by one of two active-low address strobes, which are gated differently. After the strobe, a two-bit counter steps through the rest of an aligned four-word group each cycle that the advance input is low. The group is walked in linear or interleaved order.

A read has a 2-1-1-1 shape. Data for the strobed address appears two clock edges after the strobe is presented. Each later beat follows one edge after the previous one. Writes are done per byte. A global write strobe stores the whole word. Otherwise each byte lane is written when its own enable is low and the byte-write gate is also low. While a chip is selected, every cycle with no write is a read of the current burst address. The array depth is `2**ADDR_W`: 16 gives the full 64K-word configuration, and the default of 10 keeps elaboration small.

Top module: `burst_sram`

## Requirements
- R1: After reset, and until a selected read completes, `dq_drv` is 0 and `dq_o` is all zeros.
- R2: A cycle that opens a burst while the chip is not selected deselects the block. The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. While deselected, no data is driven and no write reaches the array.
- R3: A processor strobe (`proc_strobe_n`=0) is ignored while `sel_a_n`=1, so a burst already running continues. A controller strobe (`ctrl_strobe_n`=0) is never blocked by `sel_a_n`.
- R4: When a processor strobe is accepted, it wins over a controller strobe presented in the same cycle. The strobe cycle is always a read: write controls in that cycle are ignored.
- R5: A controller strobe cycle that has any write enable active writes `dq_i` to `addr_i` in that same cycle.
- R6: A read presented before clock edge k drives its data on `dq_o`, with `dq_drv`=1, after edge k+1, provided `oe_n`=0.
- R7: With `interleave_i`=0 latched at the strobe, beat i addresses `{base[ADDR_W-1:2], (base[1:0]+i) mod 4}`. The burst never leaves its aligned group of four words.
- R8: With `interleave_i`=1 latched at the strobe, beat i addresses `{base[ADDR_W-1:2], base[1:0] XOR i}`.
- R9: When no strobe is accepted and `adv_n`=1, the burst address holds. The same word is accessed again.
- R10: Byte lane 0 is `dq[8:0]`, with data in `dq[7:0]` and parity in `dq[8]`. Lane 1 is `dq[17:9]`, with data in `dq[16:9]` and parity in `dq[17]`. `byte_we_n[0]` selects lane 0 and `byte_we_n[1]` selects lane 1. A lane that is not written keeps its contents.
- R11: `byte_we_n` acts only when `bytewr_en_n`=0. `all_wr_n`=0 writes both lanes whatever the values of `bytewr_en_n` and `byte_we_n`.
- R12: A write issued in the cycle immediately before a read of the same address makes that read return the newly written word.
- R13: `oe_n`=1 forces `dq_drv` to 0 and `dq_o` to zero without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr_i | input | ADDR_W | Word address sampled on a strobe |
| dq_i | input | 18 | Write data (two lanes of 8 data bits plus parity) |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by `sel_a_n` |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, never gated |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| bytewr_en_n | input | 1 | Gate for the per-lane write enables, active low |
| byte_we_n | input | 2 | Per-lane write enables, active low |
| all_wr_n | input | 1 | Whole-word write, active low, overrides the lane controls |
| interleave_i | input | 1 | Burst order latched at the strobe: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 18 | Read data, zero when not driven |
| dq_drv | output | 1 | High while `dq_o` carries valid read data |

## Verification
The bound checker checks these properties on every cycle:
- output enable always suppresses the drive;
- a blocked or absent strobe leaves the burst base alone;
- a processor strobe cycle never becomes a write;
- with every write control inactive, no write is issued;
- the burst address stays inside its aligned group and holds when advance is high;
- a deselecting strobe leaves no access behind;
- every read access is followed by drive unless output enable is high.

Some properties need data and the address ordering, so only the bench scenarios can show them. Against a reference array they cover:
- the exact linear and interleaved beat sequences;
- the byte-lane merge rules;
- the value returned by a read that directly follows a write.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES   = 2;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BEAT_W  = 2;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_pkg::*;
(
  input  logic       bytewr_en_n,
  input  lane_mask_t byte_we_n,
  input  logic       all_wr_n,
  output lane_mask_t wr_mask
);
  // whole-word write wins; lane enables only count when gated on
  always_comb begin
    if (!all_wr_n)
      wr_mask = '1;
    else if (!bytewr_en_n)
      wr_mask = ~byte_we_n;
    else
      wr_mask = '0;
  end
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              chip_sel,
  input  logic              interleave_i,
  input  lane_mask_t        wr_mask_i,
  output logic              acc_vld,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output lane_mask_t        acc_mask,
  output word_t             acc_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              active_q
);
  localparam int HI_W = ADDR_W - BEAT_W;

  beat_t             cnt_q, cnt_nx;
  logic              mode_q, mode_nx;
  logic              p_load, c_load, load, step;
  logic [ADDR_W-1:0] base_nx;
  logic              act_nx;
  beat_t             lo_nx;
  logic              wr_nx;

  always_comb begin
    p_load  = !proc_strobe_n && !sel_a_n;
    c_load  = !ctrl_strobe_n && !p_load;
    load    = p_load || c_load;
    step    = !load && active_q && !adv_n;
    cnt_nx  = load ? '0 : (step ? cnt_q + beat_t'(1) : cnt_q);
    base_nx = load ? addr_i : base_q;
    act_nx  = load ? chip_sel : active_q;
    mode_nx = load ? interleave_i : mode_q;
    lo_nx   = mode_nx ? (base_nx[BEAT_W-1:0] ^ cnt_nx)
                      : (base_nx[BEAT_W-1:0] + cnt_nx);
    // a processor strobe cycle is forced to a read
    wr_nx   = act_nx && !p_load && (|wr_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mode_q    <= 1'b0;
      base_q    <= '0;
      active_q  <= 1'b0;
      acc_vld   <= 1'b0;
      acc_wr    <= 1'b0;
      acc_addr  <= '0;
      acc_mask  <= '0;
      acc_wdata <= '0;
    end else begin
      cnt_q     <= cnt_nx;
      mode_q    <= mode_nx;
      base_q    <= base_nx;
      active_q  <= act_nx;
      acc_vld   <= act_nx;
      acc_wr    <= wr_nx;
      acc_addr  <= {base_nx[ADDR_W-1 -: HI_W], lo_nx};
      acc_mask  <= wr_nx ? wr_mask_i : '0;
      acc_wdata <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  lane_mask_t        acc_mask,
  input  word_t             acc_wdata,
  output word_t             rd_data,
  output logic              rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (acc_vld && acc_mask[g])
        mem[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rd_q <= '0;
      else if (acc_vld && !acc_wr)
        rd_q <= mem[acc_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_vld <= 1'b0;
    else
      rd_vld <= acc_vld && !acc_wr;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] dq_i,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              bytewr_en_n,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic              all_wr_n,
  input  logic              interleave_i,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_drv
);
  logic              chip_sel;
  lane_mask_t        wr_mask;
  logic              acc_vld, acc_wr, active_q;
  logic [ADDR_W-1:0] acc_addr, base_q;
  lane_mask_t        acc_mask;
  word_t             acc_wdata, rd_data;
  logic              rd_vld;

  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  sram_wr_decode u_wr_decode (
    .bytewr_en_n (bytewr_en_n),
    .byte_we_n   (byte_we_n),
    .all_wr_n    (all_wr_n),
    .wr_mask     (wr_mask)
  );

  sram_burst_ctl #(.ADDR_W(ADDR_W)) u_burst_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i),
    .wdata_i       (dq_i),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .sel_a_n       (sel_a_n),
    .chip_sel      (chip_sel),
    .interleave_i  (interleave_i),
    .wr_mask_i     (wr_mask),
    .acc_vld       (acc_vld),
    .acc_wr        (acc_wr),
    .acc_addr      (acc_addr),
    .acc_mask      (acc_mask),
    .acc_wdata     (acc_wdata),
    .base_q        (base_q),
    .active_q      (active_q)
  );

  sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (acc_vld),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_mask  (acc_mask),
    .acc_wdata (acc_wdata),
    .rd_data   (rd_data),
    .rd_vld    (rd_vld)
  );

  // asynchronous output gate
  assign dq_drv = rd_vld && !oe_n;
  assign dq_o   = dq_drv ? rd_data : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              adv_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              all_wr_n,
  input logic              bytewr_en_n,
  input logic              oe_n,
  input logic              dq_drv,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic              active_q
);
  assert_oe_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drv);

  assert_proc_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_strobe_n && (proc_strobe_n || sel_a_n)) |=> $stable(base_q));

  assert_proc_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !sel_a_n) |=> !acc_wr);

  assert_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (all_wr_n && bytewr_en_n) |=> !acc_wr);

  assert_group_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> (acc_addr[ADDR_W-1:2] == base_q[ADDR_W-1:2]));

  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && adv_n && ctrl_strobe_n && (proc_strobe_n || sel_a_n))
      |=> $stable(acc_addr));

  assert_read_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr) |=> (dq_drv || oe_n));

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strobe_n && !(!proc_strobe_n && !sel_a_n)
      && !(!sel_a_n && sel_b && !sel_c_n)) |=> !acc_vld);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .adv_n         (adv_n),
  .sel_a_n       (sel_a_n),
  .sel_b         (sel_b),
  .sel_c_n       (sel_c_n),
  .all_wr_n      (all_wr_n),
  .bytewr_en_n   (bytewr_en_n),
  .oe_n          (oe_n),
  .dq_drv        (dq_drv),
  .acc_vld       (acc_vld),
  .acc_wr        (acc_wr),
  .acc_addr      (acc_addr),
  .base_q        (base_q),
  .active_q      (active_q)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic [17:0]   dq_i;
  logic          proc_strobe_n, ctrl_strobe_n, adv_n;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          bytewr_en_n, all_wr_n, interleave_i, oe_n;
  logic [1:0]    byte_we_n;
  logic [17:0]   dq_o;
  logic          dq_drv;

  logic [17:0]   ref_mem [0:(1<<AW)-1];
  int            n_chk  = 0;
  int            n_fail = 0;
  bit            done   = 0;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .dq_i(dq_i),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .bytewr_en_n(bytewr_en_n), .byte_we_n(byte_we_n), .all_wr_n(all_wr_n),
    .interleave_i(interleave_i), .oe_n(oe_n), .dq_o(dq_o), .dq_drv(dq_drv)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    proc_strobe_n = 1; ctrl_strobe_n = 1; adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    bytewr_en_n = 1; byte_we_n = 2'b11; all_wr_n = 1;
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input string req, input logic [17:0] exp);
    check(dq_drv === 1'b1 && dq_o === exp, req, dq_o, exp);
  endtask

  task automatic expect_quiet(input string req);
    check(dq_drv === 1'b0 && dq_o === 18'h0, req, dq_o, 18'h0);
  endtask

  // controller-strobe write; the reference merge follows R10/R11
  task automatic wr_ctl(input logic [AW-1:0] a, input logic [17:0] d,
                        input logic gw_n, input logic bwe_n, input logic [1:0] bn);
    logic [1:0] m;
    idle();
    addr_i = a; dq_i = d; ctrl_strobe_n = 0;
    all_wr_n = gw_n; bytewr_en_n = bwe_n; byte_we_n = bn;
    m = !gw_n ? 2'b11 : (!bwe_n ? ~bn : 2'b00);
    if (m[0]) ref_mem[a][8:0]  = d[8:0];
    if (m[1]) ref_mem[a][17:9] = d[17:9];
    tick();
    idle();
  endtask

  task automatic rd_one(input logic [AW-1:0] a, input string req);
    idle();
    addr_i = a; ctrl_strobe_n = 0;
    tick();
    idle();
    tick();
    expect_word(req, ref_mem[a]);
  endtask

  task automatic t_reset();
    expect_quiet("R1 after reset");
    tick();
    expect_quiet("R1 idle cycle");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) wr_ctl(AW'(10'h40 + i), 18'h10A00 + 18'(i * 3), 0, 1, 2'b11);
    wr_ctl(10'h10, 18'h2F0F0, 0, 1, 2'b11);
    wr_ctl(10'h20, 18'h15555, 0, 1, 2'b11);
    rd_one(10'h41, "R5/R6 single read");
    rd_one(10'h10, "R5/R6 single read");
  endtask

  task automatic t_burst(input logic [AW-1:0] start, input logic mode, input string req);
    logic [1:0] lo;
    idle();
    addr_i = start; interleave_i = mode; ctrl_strobe_n = 0;
    tick();
    idle(); adv_n = 0;
    tick();
    for (int i = 0; i < 4; i++) begin
      if (i > 0) tick();
      lo = mode ? (start[1:0] ^ 2'(i)) : (start[1:0] + 2'(i));
      expect_word(req, ref_mem[{start[AW-1:2], lo}]);
    end
    idle();
  endtask

  task automatic t_hold();
    idle(); addr_i = 10'h40; interleave_i = 0; ctrl_strobe_n = 0;
    tick();
    idle(); adv_n = 0; tick(); expect_word("R9 beat0", ref_mem[10'h40]);
    adv_n = 1;          tick(); expect_word("R9 beat1", ref_mem[10'h41]);
                        tick(); expect_word("R9 held", ref_mem[10'h41]);
    adv_n = 0;          tick(); expect_word("R9 held", ref_mem[10'h41]);
                        tick(); expect_word("R9 resumed", ref_mem[10'h42]);
    idle();
  endtask

  task automatic t_proc_blocked();
    idle(); addr_i = 10'h40; interleave_i = 0; ctrl_strobe_n = 0;
    tick();
    idle(); adv_n = 0; proc_strobe_n = 0; sel_a_n = 1; addr_i = 10'h10;
    tick(); expect_word("R3 beat0", ref_mem[10'h40]);
    idle(); adv_n = 0;
    tick(); expect_word("R3 burst kept", ref_mem[10'h41]);
    tick(); expect_word("R3 burst kept", ref_mem[10'h42]);
    idle();
  endtask

  task automatic t_proc_read();
    idle(); addr_i = 10'h20; proc_strobe_n = 0; ctrl_strobe_n = 0;
    all_wr_n = 0; dq_i = 18'h3ABCD;
    tick();
    idle();
    tick(); expect_word("R4 strobe cycle reads", ref_mem[10'h20]);
    rd_one(10'h20, "R4 no write");
  endtask

  task automatic t_bytes();
    wr_ctl(10'h30, 18'h3FFFF, 0, 1, 2'b11);
    wr_ctl(10'h30, 18'h00000, 1, 0, 2'b10);
    rd_one(10'h30, "R10 lane0 only");
    wr_ctl(10'h30, 18'h00000, 1, 0, 2'b01);
    rd_one(10'h30, "R10 lane1 only");
    wr_ctl(10'h30, 18'h12345, 1, 1, 2'b00);
    rd_one(10'h30, "R11 gated lanes ignored");
    wr_ctl(10'h30, 18'h2A5A5, 0, 1, 2'b11);
    rd_one(10'h30, "R11 global write");
  endtask

  task automatic t_raw();
    idle(); addr_i = 10'h50; dq_i = 18'h0C3C3; ctrl_strobe_n = 0; all_wr_n = 0;
    ref_mem[10'h50] = 18'h0C3C3;
    tick();
    idle(); addr_i = 10'h50; ctrl_strobe_n = 0; dq_i = 18'h3FFFF;
    tick();
    idle();
    tick(); expect_word("R12 read after write", ref_mem[10'h50]);
  endtask

  task automatic t_deselect();
    idle(); addr_i = 10'h20; sel_b = 0; ctrl_strobe_n = 0; all_wr_n = 0; dq_i = 18'h00001;
    tick();
    idle();
    tick(); expect_quiet("R2 sel_b low");
    tick(); expect_quiet("R2 stays deselected");
    rd_one(10'h20, "R2 no write while deselected");
    idle(); addr_i = 10'h40; sel_a_n = 1; ctrl_strobe_n = 0;
    tick();
    idle();
    tick(); expect_quiet("R3 controller strobe not blocked, deselects");
    idle(); addr_i = 10'h40; sel_c_n = 1; ctrl_strobe_n = 0;
    tick();
    idle();
    tick(); expect_quiet("R2 sel_c_n high");
  endtask

  task automatic t_oe();
    rd_one(10'h40, "R13 setup");
    oe_n = 1; #1;
    expect_quiet("R13 oe high");
    oe_n = 0; #1;
    expect_word("R13 oe low", ref_mem[10'h40]);
  endtask

  initial begin
    rst_n = 0; addr_i = '0; dq_i = '0; interleave_i = 0; oe_n = 0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_fill();
    t_burst(10'h42, 0, "R7 linear");
    t_burst(10'h41, 1, "R8 interleaved");
    t_burst(10'h43, 1, "R8 interleaved");
    t_hold();
    t_proc_blocked();
    t_proc_read();
    t_bytes();
    t_raw();
    t_deselect();
    t_oe();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 18'h0, 18'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule